// File: doc/BRIEF.md
# Dual-Channel Video Line CRC Unit

This block works on a 20-bit HD video word stream that carries two 10-bit channels, the upper one in bits 19:10 and the lower one in bits 9:0. It finds the line structure by itself. It watches the lower channel for the timing reference sequence, which is an all-ones word followed by two all-zeros words and then a flag word. From that sequence it tells the start of active video from the end of active video. Each channel has its own 18-bit line CRC, and both CRCs use the same word positions.

In generate mode, each CRC result is written into the two CRC word slots of its channel. These slots follow the end-of-active-video reference and the two line-number words. All other words pass through unchanged.

In check mode, the block recomputes both CRCs and compares them with the received CRC words. It flags a mismatch with a single-word error pulse that lines up with the second CRC word on the output. Every word, in either mode, leaves the block exactly one clock after it enters.

Top module: `hdline_crc`

## Requirements
- R1: While reset is held and after it is released, `crc_err` is low, and no CRC slot is recognised until a new timing reference has been seen.
- R2: A word is a flag word when the three words before it on the lower channel are 3FF, 000, 000 (hex). Bit 6 of the flag word set to 1 marks end of active video. Bit 6 set to 0 marks start of active video. The four words that follow an end flag are line-number 0, line-number 1, CRC slot 0 and CRC slot 1, in that order.
- R3: Each channel CRC uses the polynomial x^18 + x^5 + x^4 + 1 and takes each word least significant bit first. For every data bit d, the 18-bit register c is updated as follows: f = c[0] xor d, then c is shifted right by one, then 0x23000 is XORed into c when f is 1. The register starts at zero.
- R4: A channel CRC covers every word from the one after a start flag up to and including line-number 1. It is cleared at every start flag and again after CRC slot 1.
- R5: In generate mode (`check_mode` = 0) with `ins_en` = 1, the output word in CRC slot 0 carries CRC bits 8:0 in bits 8:0. The output word in CRC slot 1 carries CRC bits 17:9 in bits 8:0. In both words, bit 9 is the inverse of bit 8.
- R6: Every word that is not replaced appears unchanged on `dout` one clock after it is on `din`. This includes every word when `ins_en` = 0 and every word in check mode.
- R7: The two channels keep separate CRCs. The upper channel CRC is computed over bits 19:10 and inserted into or checked against bits 19:10.
- R8: In check mode, `crc_err` is 1 for exactly the clock in which `dout` shows CRC slot 1. It is set only when any of the 10 bits of either channel's CRC slot 0 or CRC slot 1 differs from the value given in R5. In every other clock it is 0.
- R9: After reset, `crc_err` stays low until a start flag and then an end flag have both been seen. CRC slots seen before that point are ignored.
- R10: In generate mode, `crc_err` is never set, whatever the CRC slot contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| check_mode | input | 1 | 0 = generate, 1 = check |
| ins_en | input | 1 | Enables CRC insertion in generate mode |
| din | input | 20 | Input word, upper channel in 19:10, lower in 9:0 |
| dout | output | 20 | Output word, one clock behind `din` |
| crc_err | output | 1 | Single-word CRC mismatch flag in check mode |

## Verification
The bench sweeps the length of the active region and the data contents over many lines. A design that ended accumulation one word early or late, or that cleared between lines at the wrong time, would insert wrong CRCs. It then corrupts single bits in each CRC slot of each channel, including the inverted bit 9. A checker that compared too few bits, or only one channel, would miss these errors. A checker whose error pulse was misplaced or stretched would fail the per-word comparison. It also starts a check run in the middle of a line with bad CRCs, to catch a checker that reports before it is armed. Finally, it feeds bad CRCs in generate mode with insertion off, to catch an error flag that leaks out of check mode.

// File: rtl/hdcrc_pkg.sv
package hdcrc_pkg;
  localparam int CH_W   = 10;
  localparam int CRC_W  = 18;
  localparam int HALF_W = CRC_W / 2;
  localparam int XYZ_H  = 6;
  localparam logic [CRC_W-1:0] DEF_TAPS = 18'h23000;

  localparam logic [2:0] POS_LN0 = 3'd1;
  localparam logic [2:0] POS_LN1 = 3'd2;
  localparam logic [2:0] POS_C0  = 3'd3;
  localparam logic [2:0] POS_C1  = 3'd4;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [CRC_W-1:0] crc_t;

  // LSB-first serial CRC over one channel word, shift-right form
  function automatic crc_t crc_step(input crc_t c, input chan_t w, input crc_t taps);
    crc_t r;
    r = c;
    for (int b = 0; b < CH_W; b++) begin
      logic fb;
      fb = r[0] ^ w[b];
      r  = r >> 1;
      if (fb) r = r ^ taps;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdcrc_trs.sv
module hdcrc_trs
  import hdcrc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  chan_t w,
  output logic  sav,
  output logic  eav,
  output logic  acc,
  output logic  slot0,
  output logic  slot1
);
  chan_t h0, h1, h2;
  logic acc_q;
  logic [2:0] pos_q;
  logic trs_hit;

  always_comb begin
    trs_hit = (h2 == '1) && (h1 == '0) && (h0 == '0);
    sav   = trs_hit && !w[XYZ_H];
    eav   = trs_hit &&  w[XYZ_H];
    acc   = acc_q;
    slot0 = (pos_q == POS_C0);
    slot1 = (pos_q == POS_C1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
      acc_q <= 1'b0;
      pos_q <= '0;
    end else begin
      h0 <= w; h1 <= h0; h2 <= h1;
      if (sav) acc_q <= 1'b1;
      else if (pos_q == POS_LN1) acc_q <= 1'b0;
      if (eav) pos_q <= POS_LN0;
      else if (pos_q == POS_C1) pos_q <= '0;
      else if (pos_q != '0) pos_q <= pos_q + 3'd1;
    end
  end

  assert_slot_order_R2: assert property (@(posedge clk) disable iff (rst)
    slot0 |=> slot1);
  assert_span_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_q, slot0, slot1}));
endmodule

// File: rtl/hdcrc_lane.sv
module hdcrc_lane
  import hdcrc_pkg::*;
#(
  parameter crc_t TAPS = DEF_TAPS
)(
  input  logic  clk,
  input  logic  rst,
  input  chan_t w_in,
  input  logic  acc,
  input  logic  clr,
  input  logic  slot0,
  input  logic  slot1,
  input  logic  ins,
  output chan_t w_out,
  output logic  mism
);
  crc_t crc_q;
  chan_t exp0, exp1;

  always_comb begin
    exp0 = {~crc_q[HALF_W-1], crc_q[HALF_W-1:0]};
    exp1 = {~crc_q[CRC_W-1], crc_q[CRC_W-1:HALF_W]};
    if (ins && slot0)      w_out = exp0;
    else if (ins && slot1) w_out = exp1;
    else                   w_out = w_in;
    mism = (slot0 && (w_in != exp0)) || (slot1 && (w_in != exp1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (acc)   crc_q <= crc_step(crc_q, w_in, TAPS);
  end

  assert_clear_after_slot_R4: assert property (@(posedge clk) disable iff (rst)
    slot1 |=> (crc_q == '0));
endmodule

// File: rtl/hdline_crc.sv
module hdline_crc
  import hdcrc_pkg::*;
#(
  parameter int   N_LANE = 2,
  parameter crc_t TAPS   = DEF_TAPS
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   check_mode,
  input  logic                   ins_en,
  input  logic [N_LANE*CH_W-1:0] din,
  output logic [N_LANE*CH_W-1:0] dout,
  output logic                   crc_err
);
  localparam int BUS_W = N_LANE * CH_W;

  logic sav, eav, acc, slot0, slot1, clr, ins;
  logic [N_LANE-1:0] mism;
  logic [BUS_W-1:0] dnext, dout_q;
  logic seen_sav, armed, mm_q, err_q;

  assign clr = sav || slot1;
  assign ins = !check_mode && ins_en;

  hdcrc_trs u_trs (
    .clk(clk), .rst(rst), .w(din[CH_W-1:0]),
    .sav(sav), .eav(eav), .acc(acc), .slot0(slot0), .slot1(slot1)
  );

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    hdcrc_lane #(.TAPS(TAPS)) u_lane (
      .clk(clk), .rst(rst), .w_in(din[g*CH_W +: CH_W]),
      .acc(acc), .clr(clr), .slot0(slot0), .slot1(slot1), .ins(ins),
      .w_out(dnext[g*CH_W +: CH_W]), .mism(mism[g])
    );
  end

  always_ff @(posedge clk) dout_q <= dnext;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_sav <= 1'b0;
      armed    <= 1'b0;
      mm_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (sav) seen_sav <= 1'b1;
      if (eav && seen_sav) armed <= 1'b1;
      if (slot0) mm_q <= |mism;
      err_q <= check_mode && armed && slot1 && (mm_q || (|mism));
    end
  end

  assign dout    = dout_q;
  assign crc_err = err_q;

  assert_err_in_slot1_R8: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> $past(slot1));
  assert_err_check_only_R10: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> $past(check_mode));
  assert_pass_through_R6: assert property (@(posedge clk) disable iff (rst)
    (!check_mode && !ins_en) |=> (dout == $past(din)));
endmodule

// File: tb/tb_hdline_crc.sv
module tb_hdline_crc;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, check_mode, ins_en;
  logic [19:0] din;
  logic [19:0] dout;
  logic crc_err;

  hdline_crc dut (
    .clk(clk), .rst(rst), .check_mode(check_mode), .ins_en(ins_en),
    .din(din), .dout(dout), .crc_err(crc_err)
  );

  int n_chk = 0, n_fail = 0;
  logic pend = 1'b0;
  logic [19:0] exp_w;
  logic exp_e;
  string exp_tag;
  logic [17:0] mc [2];
  logic sav_m, armed_m;

  // R3: bitwise reference CRC, LSB first
  function automatic logic [17:0] bcrc(input logic [17:0] c, input logic [9:0] d);
    logic [17:0] r;
    r = c;
    for (int b = 0; b < 10; b++) begin
      logic fb;
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ 18'h23000;
    end
    return r;
  endfunction

  task automatic compare();
    if (pend) begin
      n_chk++;
      if (dout !== exp_w || crc_err !== exp_e) begin
        n_fail++;
        $display("FAIL %s: dout=%h crc_err=%b expected dout=%h crc_err=%b",
                 exp_tag, dout, crc_err, exp_w, exp_e);
      end
    end
  endtask

  task automatic put(input logic [19:0] w, input logic [19:0] ew, input logic ee, input string tag);
    @(negedge clk);
    compare();
    din = w; pend = 1'b1; exp_w = ew; exp_e = ee; exp_tag = tag;
  endtask

  task automatic accum(input logic [19:0] w);
    mc[0] = bcrc(mc[0], w[9:0]);
    mc[1] = bcrc(mc[1], w[19:10]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    pend = 1'b0; rst = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (crc_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: crc_err=%b expected 0 in reset", crc_err);
    end
    rst = 1'b0; sav_m = 1'b0; armed_m = 1'b0;
    mc[0] = '0; mc[1] = '0;
  endtask

  // one line: [SAV] active, EAV, LN0, LN1, CRC0, CRC1, blanking
  task automatic line(input int nact, input int seed, input bit with_sav,
                      input int cor_slot, input int cor_lane, input int cor_bit);
    logic [19:0] w, sent, expo;
    logic bad;
    bad = 1'b0;
    if (with_sav) begin // R2 start flag
      put(20'hFFFFF, 20'hFFFFF, 1'b0, "R6");
      put(20'h0, 20'h0, 1'b0, "R6");
      put(20'h0, 20'h0, 1'b0, "R6");
      put({10'h200, 10'h200}, {10'h200, 10'h200}, 1'b0, "R2 R6");
      sav_m = 1'b1; mc[0] = '0; mc[1] = '0;
    end
    for (int i = 0; i < nact; i++) begin
      w[9:0]   = 10'(1 + ((seed * 131 + i * 29) % 1020));
      w[19:10] = 10'(1 + ((seed * 71 + i * 53 + 7) % 1020));
      accum(w);
      put(w, w, 1'b0, "R6");
    end
    // R4: end reference and line numbers are inside the CRC span
    w = 20'hFFFFF; accum(w); put(w, w, 1'b0, "R6");
    w = 20'h0; accum(w); put(w, w, 1'b0, "R6");
    w = 20'h0; accum(w); put(w, w, 1'b0, "R6");
    w = {10'h274, 10'h274}; accum(w); put(w, w, 1'b0, "R2 R6");
    if (sav_m) armed_m = 1'b1;
    w = {10'h200 | 10'((seed & 63) << 2), 10'h204}; accum(w); put(w, w, 1'b0, "R4 R6");
    w = {10'h200, 10'h200 | 10'(nact << 2)}; accum(w); put(w, w, 1'b0, "R4 R6");
    for (int s = 1; s <= 2; s++) begin
      logic [19:0] ev;
      if (s == 1) ev = {~mc[1][8], mc[1][8:0], ~mc[0][8], mc[0][8:0]};
      else        ev = {~mc[1][17], mc[1][17:9], ~mc[0][17], mc[0][17:9]};
      sent = check_mode ? ev : 20'h55155;
      if (cor_slot == s) sent[cor_lane * 10 + cor_bit] = ~sent[cor_lane * 10 + cor_bit];
      if (sent != ev) bad = 1'b1;
      expo = (!check_mode && ins_en) ? ev : sent;
      if (s == 1) put(sent, expo, 1'b0, "R3 R5 R7");
      else put(sent, expo, check_mode && armed_m && bad, "R3 R5 R7 R8 R9 R10");
    end
    for (int k = 0; k < 3; k++) put(20'h10040, 20'h10040, 1'b0, "R6");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; check_mode = 1'b0; ins_en = 1'b1; din = '0;
    sav_m = 1'b0; armed_m = 1'b0; mc[0] = '0; mc[1] = '0;
    do_reset();
    // R5 R7: generate sweep over line length and content
    for (int n = 1; n <= 12; n++)
      for (int sd = 0; sd < 4; sd++)
        line(n, sd + n * 5, 1'b1, 0, 0, 0);
    // R6: insertion off, garbage slots pass unchanged
    ins_en = 1'b0;
    for (int n = 2; n <= 4; n++) line(n, n, 1'b1, 0, 0, 0);
    // R10: bad slots in generate mode never raise the flag
    line(3, 9, 1'b1, 1, 1, 4);
    // R9: check run starting mid-line, bad CRC ignored
    check_mode = 1'b1;
    do_reset();
    line(5, 11, 1'b0, 1, 0, 2);
    line(4, 12, 1'b0, 2, 1, 7);
    // R8: correct lines, then single-bit corruptions
    for (int n = 1; n <= 6; n++) line(n, 20 + n, 1'b1, 0, 0, 0);
    for (int b = 0; b < 10; b++) begin
      line(3, 40 + b, 1'b1, 1, b % 2, b);
      line(2, 60 + b, 1'b1, 0, 0, 0);
      line(4, 80 + b, 1'b1, 2, (b + 1) % 2, b);
    end
    line(5, 99, 1'b1, 1, 0, 9);
    line(5, 98, 1'b1, 2, 1, 9);
    put(20'h10040, 20'h10040, 1'b0, "R6");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule